// File: doc/BRIEF.md
# Address-Generation Interlock Issue Controller

This block picks, each cycle, at most one instruction to send into a short in-order integer pipeline that is shared by several hardware thread contexts. In that pipeline the effective address of a memory operand is formed in a stage of its own, the second decode stage, which comes ahead of the stage that fetches the data. A register result produced by one instruction is therefore not ready in time to serve as the address of the instruction right after it. The controller holds back such an address-consuming instruction until the producer is far enough ahead. The gap is two issue slots in the default configuration.

Every thread context presents one decoded descriptor: a valid flag, a destination register with a flag saying whether it is written, a base and an index register, and a flag saying the base and index feed address generation. Each thread keeps a short window of the registers it wrote in its most recent issue slots. A thread whose head instruction forms an address from a register in that window is held. Among the threads that are not held, a round-robin picker chooses the one that follows the thread that issued last. A held thread's dead slots are filled by the other threads whenever they have ready work. A bubble is reported only when some thread has work and none of them may issue. A saturating counter totals those bubble cycles.

The consumer of `issue_grant` advances the granted thread's instruction stream on the clock edge that ends the cycle.

Top module: `agi_issue_ctrl`

Issue slot classes (combinational, one per cycle): `SLOT_ISSUE` when at least one valid thread is not held; `SLOT_BUBBLE` when valid threads exist but all are held; `SLOT_IDLE` when no thread is valid. There is no stored state machine. The only state is the per-thread write windows, the last-issuer register and the bubble counter.

## Requirements
- R1: In a `SLOT_ISSUE` cycle, `issue_valid` is 1, `issue_grant` has exactly one bit set at position `issue_tid`, and that thread's `thr_valid` bit is 1. At most one instruction issues per cycle.
- R2: An instruction with `thr_mem_addr`=1 whose base register equals the destination of a register-writing instruction issued by the same thread in the previous slot is held. With no other thread ready, exactly two bubble cycles separate the two issues.
- R3: The same hold applies when the match is on the index register instead of the base register.
- R4: No hold occurs when the consumer has `thr_mem_addr`=0, or when the earlier instruction has `thr_writes`=0, even if the register numbers match. Such pairs issue in consecutive cycles.
- R5: The window covers the writes of the two most recent issue slots of the thread. A consumer of a register written two slots earlier, with an unrelated write in between, is held for one cycle.
- R6: Write windows are per thread. A write from one thread never holds another thread's address instruction.
- R7: The picker grants the first ready thread in ascending order, wrapping, starting after the thread that issued last. After reset the search starts at thread 0.
- R8: While a thread is held, any other ready thread issues in its dead slots. `bubble` is 1 exactly when at least one thread is valid and none may issue, and then `issue_valid` is 0.
- R9: With no valid thread, `issue_valid` and `bubble` are both 0.
- R10: `stall_count` is 0 after reset and rises by one per bubble cycle. It saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_valid | input | NUM_THREADS | Thread t has an instruction ready for issue |
| thr_dest | input | NUM_THREADS*REG_W | Destination register per thread, slice t at [t*REG_W +: REG_W] |
| thr_writes | input | NUM_THREADS | Instruction writes its destination register |
| thr_base | input | NUM_THREADS*REG_W | Base register per thread |
| thr_index | input | NUM_THREADS*REG_W | Index register per thread |
| thr_mem_addr | input | NUM_THREADS | Base and index feed address generation |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Thread that issues (0 when none) |
| issue_grant | output | NUM_THREADS | One-hot grant, consumed at the next clock edge |
| bubble | output | 1 | Valid work exists but every thread is held |
| stall_count | output | CNT_W | Saturating count of bubble cycles |

## Verification
The hardest condition to reach from the ports is a hold caused by the older of the two window entries. The thread must issue two writes back to back, and then present an address use of the first destination but not the second. The bench builds per-thread instruction streams whose heads advance on each grant. That makes the producer, an unrelated writer and then the consumer reach the picker in successive cycles, so the one-cycle residual hold can be seen. Filling of dead slots is reached the same way, by giving a second thread a stream length that covers none, one or both dead slots. Counter saturation uses a reduced counter width and two dependent pairs in a row.

// File: rtl/agi_pkg.sv
package agi_pkg;

    // Classification of one issue slot.
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_ISSUE  = 2'd1,
        SLOT_BUBBLE = 2'd2
    } slot_kind_t;

endpackage

// File: rtl/agi_hazard_window.sv
// Per-thread record of register writes issued in the last DEPTH slots.
// Each clock edge shifts the record by one slot, whether or not the
// thread issued, because the producer moves down the pipeline anyway.
module agi_hazard_window #(
    parameter int REG_W = 5,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [REG_W-1:0] push_reg,
    input  logic             addr_use,
    input  logic [REG_W-1:0] base_reg,
    input  logic [REG_W-1:0] index_reg,
    output logic             blocked
);

    logic [DEPTH-1:0] slot_vld;
    logic [REG_W-1:0] slot_reg [DEPTH];
    logic [DEPTH-1:0] slot_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                slot_vld[s] <= 1'b0;
                slot_reg[s] <= '0;
            end
        end else begin
            slot_vld[0] <= push;
            slot_reg[0] <= push_reg;
            for (int s = 1; s < DEPTH; s++) begin
                slot_vld[s] <= slot_vld[s-1];
                slot_reg[s] <= slot_reg[s-1];
            end
        end
    end

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
            assign slot_hit[s] = slot_vld[s] &&
                                 ((slot_reg[s] == base_reg) || (slot_reg[s] == index_reg));
        end
    endgenerate

    assign blocked = addr_use && (|slot_hit);

endmodule

// File: rtl/agi_rr_picker.sv
// Round-robin choice among ready threads, searching from last_tid+1 upward.
module agi_rr_picker #(
    parameter  int NT   = 4,
    localparam int TW   = $clog2(NT)
) (
    input  logic [NT-1:0] req,
    input  logic [TW-1:0] last_tid,
    output logic [NT-1:0] grant,
    output logic [TW-1:0] grant_tid,
    output logic          any
);

    always_comb begin
        grant     = '0;
        grant_tid = '0;
        any       = 1'b0;
        for (int k = 1; k <= NT; k++) begin
            if (!any && req[(int'(last_tid) + k) % NT]) begin
                any                              = 1'b1;
                grant[(int'(last_tid) + k) % NT] = 1'b1;
                grant_tid                        = TW'((int'(last_tid) + k) % NT);
            end
        end
    end

endmodule

// File: rtl/agi_stall_counter.sv
// Saturating count of bubble cycles.
module agi_stall_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    // R10: each bubble below the ceiling adds exactly one
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inc) && ($past(count) != CNT_MAX))
            |-> (count == $past(count) + 1'b1));

    // R10: no bubble, no change; at the ceiling, no wrap
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(inc) || ($past(count) == CNT_MAX))) |-> $stable(count));

endmodule

// File: rtl/agi_issue_ctrl.sv
module agi_issue_ctrl
    import agi_pkg::*;
#(
    parameter  int NUM_THREADS = 4,
    parameter  int REG_W       = 5,
    parameter  int AGI_GAP     = 2,
    parameter  int CNT_W       = 16,
    localparam int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS-1:0]       thr_valid,
    input  logic [NUM_THREADS*REG_W-1:0] thr_dest,
    input  logic [NUM_THREADS-1:0]       thr_writes,
    input  logic [NUM_THREADS*REG_W-1:0] thr_base,
    input  logic [NUM_THREADS*REG_W-1:0] thr_index,
    input  logic [NUM_THREADS-1:0]       thr_mem_addr,
    output logic                         issue_valid,
    output logic [TID_W-1:0]             issue_tid,
    output logic [NUM_THREADS-1:0]       issue_grant,
    output logic                         bubble,
    output logic [CNT_W-1:0]             stall_count
);

    localparam logic [TID_W-1:0] LAST_RESET = TID_W'(NUM_THREADS - 1);

    logic [NUM_THREADS-1:0] thr_held;
    logic [NUM_THREADS-1:0] thr_ready;
    logic [NUM_THREADS-1:0] pick_grant;
    logic [TID_W-1:0]       pick_tid;
    logic                   pick_any;
    logic [TID_W-1:0]       last_tid;
    slot_kind_t             slot;

    // ---------------------------------------------------------------
    // Per-thread write windows and readiness
    // ---------------------------------------------------------------
    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            agi_hazard_window #(
                .REG_W (REG_W),
                .DEPTH (AGI_GAP)
            ) u_win (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (issue_grant[t] && thr_writes[t]),
                .push_reg  (thr_dest[t*REG_W +: REG_W]),
                .addr_use  (thr_mem_addr[t]),
                .base_reg  (thr_base[t*REG_W +: REG_W]),
                .index_reg (thr_index[t*REG_W +: REG_W]),
                .blocked   (thr_held[t])
            );

            assign thr_ready[t] = thr_valid[t] && !thr_held[t];

            // R2 R3: no address use of the previous slot's write of this thread
            assert_gap1_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(issue_grant[t] && thr_writes[t])
                    && issue_grant[t] && thr_mem_addr[t])
                |-> ((thr_base[t*REG_W +: REG_W]  != $past(thr_dest[t*REG_W +: REG_W])) &&
                     (thr_index[t*REG_W +: REG_W] != $past(thr_dest[t*REG_W +: REG_W]))));

            if (AGI_GAP >= 2) begin : g_gap2
                // R5: nor of the write two slots back
                assert_gap2_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n, 2) && $past(issue_grant[t] && thr_writes[t], 2)
                        && issue_grant[t] && thr_mem_addr[t])
                    |-> ((thr_base[t*REG_W +: REG_W]  != $past(thr_dest[t*REG_W +: REG_W], 2)) &&
                         (thr_index[t*REG_W +: REG_W] != $past(thr_dest[t*REG_W +: REG_W], 2))));
            end
        end
    endgenerate

    // ---------------------------------------------------------------
    // Round-robin choice
    // ---------------------------------------------------------------
    agi_rr_picker #(
        .NT (NUM_THREADS)
    ) u_pick (
        .req       (thr_ready),
        .last_tid  (last_tid),
        .grant     (pick_grant),
        .grant_tid (pick_tid),
        .any       (pick_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_tid <= LAST_RESET;
        end else if (issue_valid) begin
            last_tid <= issue_tid;
        end
    end

    // ---------------------------------------------------------------
    // Slot classification and outputs
    // ---------------------------------------------------------------
    always_comb begin
        if (pick_any) begin
            slot = SLOT_ISSUE;
        end else if (|thr_valid) begin
            slot = SLOT_BUBBLE;
        end else begin
            slot = SLOT_IDLE;
        end
    end

    always_comb begin
        issue_valid = 1'b0;
        issue_tid   = '0;
        issue_grant = '0;
        bubble      = 1'b0;
        unique case (slot)
            SLOT_ISSUE: begin
                issue_valid = 1'b1;
                issue_tid   = pick_tid;
                issue_grant = pick_grant;
            end
            SLOT_BUBBLE: begin
                bubble = 1'b1;
            end
            SLOT_IDLE: begin
            end
            default: begin
            end
        endcase
    end

    agi_stall_counter #(
        .CNT_W (CNT_W)
    ) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bubble),
        .count (stall_count)
    );

    // R1: a grant is one-hot and names a thread that has work
    assert_grant_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (($countones(issue_grant) == 1) && thr_valid[issue_tid]
                         && issue_grant[issue_tid]));

    // R8: a bubble only while work waits and nothing issues
    assert_bubble_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> ((|thr_valid) && !issue_valid && (issue_grant == '0)));

    // R9: with no work the slot is quiet
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|thr_valid) |-> (!issue_valid && !bubble));

endmodule

// File: tb/sim_agi_issue_ctrl.sv
module sim_agi_issue_ctrl;

    localparam int NT  = 4;
    localparam int RW  = 5;
    localparam int CW  = 2;
    localparam int TW  = $clog2(NT);
    localparam int MAXI = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NT-1:0]    thr_valid;
    logic [NT*RW-1:0] thr_dest;
    logic [NT-1:0]    thr_writes;
    logic [NT*RW-1:0] thr_base;
    logic [NT*RW-1:0] thr_index;
    logic [NT-1:0]    thr_mem_addr;
    logic             issue_valid;
    logic [TW-1:0]    issue_tid;
    logic [NT-1:0]    issue_grant;
    logic             bubble;
    logic [CW-1:0]    stall_count;

    always #5 clk = ~clk;

    agi_issue_ctrl #(
        .NUM_THREADS (NT),
        .REG_W       (RW),
        .AGI_GAP     (2),
        .CNT_W       (CW)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_valid    (thr_valid),
        .thr_dest     (thr_dest),
        .thr_writes   (thr_writes),
        .thr_base     (thr_base),
        .thr_index    (thr_index),
        .thr_mem_addr (thr_mem_addr),
        .issue_valid  (issue_valid),
        .issue_tid    (issue_tid),
        .issue_grant  (issue_grant),
        .bubble       (bubble),
        .stall_count  (stall_count)
    );

    // ---------------- per-thread instruction streams ----------------
    logic [RW-1:0] s_dest [NT][MAXI];
    logic [RW-1:0] s_base [NT][MAXI];
    logic [RW-1:0] s_idx  [NT][MAXI];
    logic          s_mem  [NT][MAXI];
    logic          s_wr   [NT][MAXI];
    int            s_len  [NT];
    int            head   [NT];

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            thr_valid[t]              = head[t] < s_len[t];
            thr_dest[t*RW +: RW]      = s_dest[t][head[t][2:0]];
            thr_base[t*RW +: RW]      = s_base[t][head[t][2:0]];
            thr_index[t*RW +: RW]     = s_idx[t][head[t][2:0]];
            thr_mem_addr[t]           = s_mem[t][head[t][2:0]];
            thr_writes[t]             = s_wr[t][head[t][2:0]];
        end
    end

    always @(posedge clk) begin
        for (int t = 0; t < NT; t++) begin
            if (!rst_n) head[t] <= 0;
            else if (issue_grant[t]) head[t] <= head[t] + 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic  iv;
        int    tid;
        logic  bub;
        string req;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected extra slot", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(issue_valid == e.iv, e.req, "issue_valid", int'(issue_valid), int'(e.iv));
                chk(bubble == e.bub, e.req, "bubble", int'(bubble), int'(e.bub));
                if (e.iv) begin
                    chk(int'(issue_tid) == e.tid, e.req, "issue_tid", int'(issue_tid), e.tid);
                    chk(issue_grant == NT'(1 << e.tid), e.req, "issue_grant (R1)",
                        int'(issue_grant), 1 << e.tid);
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic add_ins(input int t, input int dest, input int base, input int idx,
                           input bit mem, input bit wr);
        s_dest[t][s_len[t]] = RW'(dest);
        s_base[t][s_len[t]] = RW'(base);
        s_idx[t][s_len[t]]  = RW'(idx);
        s_mem[t][s_len[t]]  = mem;
        s_wr[t][s_len[t]]   = wr;
        s_len[t]            = s_len[t] + 1;
    endtask

    // writer of register d, address user of base b / index x, plain op
    task automatic wr_op(input int t, input int d);  add_ins(t, d, 0, 0, 1'b0, 1'b1); endtask
    task automatic ld_op(input int t, input int b, input int x); add_ins(t, 0, b, x, 1'b1, 1'b0); endtask
    task automatic alu_op(input int t, input int b); add_ins(t, 0, b, b, 1'b0, 1'b0); endtask

    task automatic e_iss(input int tid, input string req);
        exp_t x; x.iv = 1'b1; x.tid = tid; x.bub = 1'b0; x.req = req; exp_q.push_back(x);
    endtask
    task automatic e_bub(input string req);
        exp_t x; x.iv = 1'b0; x.tid = 0; x.bub = 1'b1; x.req = req; exp_q.push_back(x);
    endtask
    task automatic e_idle(input string req);
        exp_t x; x.iv = 1'b0; x.tid = 0; x.bub = 1'b0; x.req = req; exp_q.push_back(x);
    endtask

    task automatic begin_scn();
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        for (int t = 0; t < NT; t++) s_len[t] = 0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(stall_count == '0, "R10", "stall_count in reset", int'(stall_count), 0);
        chk(!issue_valid && !bubble, "R9", "quiet with no threads",
            int'({issue_valid, bubble}), 0);
    endtask

    task automatic run_scn();
        int n;
        n = exp_q.size();
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        repeat (n) @(negedge clk);
        #1;
        mon_on = 1'b0;
        chk(exp_q.size() == 0, "R1", "slots left unobserved", exp_q.size(), 0);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        for (int t = 0; t < NT; t++) begin
            s_len[t] = 0;
            for (int i = 0; i < MAXI; i++) begin
                s_dest[t][i] = '0; s_base[t][i] = '0; s_idx[t][i] = '0;
                s_mem[t][i] = 1'b0; s_wr[t][i] = 1'b0;
            end
        end

        // R2: base dependency, single thread, two bubbles
        begin_scn();
        wr_op(0, 5); ld_op(0, 5, 0);
        e_iss(0, "R2"); e_bub("R2"); e_bub("R2"); e_iss(0, "R2"); e_idle("R9");
        run_scn();
        chk(stall_count == 2'd2, "R10", "stall_count after one pair", int'(stall_count), 2);

        // R3: index dependency
        begin_scn();
        wr_op(0, 7); ld_op(0, 1, 7);
        e_iss(0, "R3"); e_bub("R3"); e_bub("R3"); e_iss(0, "R3"); e_idle("R9");
        run_scn();

        // R4: plain use of a fresh write, and address use after a non-writer
        begin_scn();
        wr_op(0, 5); alu_op(0, 5);
        add_ins(0, 6, 0, 0, 1'b0, 1'b0); ld_op(0, 6, 6);
        e_iss(0, "R4"); e_iss(0, "R4"); e_iss(0, "R4"); e_iss(0, "R4"); e_idle("R9");
        run_scn();
        chk(stall_count == 2'd0, "R4", "no stall counted", int'(stall_count), 0);

        // R5: write two slots back still holds one cycle
        begin_scn();
        wr_op(0, 3); wr_op(0, 4); ld_op(0, 3, 0);
        e_iss(0, "R5"); e_iss(0, "R5"); e_bub("R5"); e_iss(0, "R5"); e_idle("R9");
        run_scn();
        chk(stall_count == 2'd1, "R5", "one residual bubble", int'(stall_count), 1);

        // R8: second thread fills both dead slots
        begin_scn();
        wr_op(0, 5); ld_op(0, 5, 0);
        alu_op(1, 9); alu_op(1, 9);
        e_iss(0, "R8"); e_iss(1, "R8"); e_iss(1, "R8"); e_iss(0, "R8"); e_idle("R9");
        run_scn();
        chk(stall_count == 2'd0, "R8", "fully hidden penalty", int'(stall_count), 0);

        // R8: second thread fills one dead slot only
        begin_scn();
        wr_op(0, 5); ld_op(0, 5, 0);
        alu_op(1, 2);
        e_iss(0, "R8"); e_iss(1, "R8"); e_bub("R8"); e_iss(0, "R8"); e_idle("R9");
        run_scn();
        chk(stall_count == 2'd1, "R8", "partly hidden penalty", int'(stall_count), 1);

        // R6: another thread's write does not hold this thread
        begin_scn();
        wr_op(0, 5); ld_op(1, 5, 5);
        e_iss(0, "R6"); e_iss(1, "R6"); e_idle("R9");
        run_scn();

        // R7: rotation across all four threads
        begin_scn();
        for (int t = 0; t < NT; t++) begin alu_op(t, 1); alu_op(t, 1); end
        for (int r = 0; r < 2; r++) for (int t = 0; t < NT; t++) e_iss(t, "R7");
        e_idle("R9");
        run_scn();

        // R7: rotation skips threads with no work and wraps
        begin_scn();
        alu_op(1, 1); alu_op(1, 1); alu_op(3, 1); alu_op(3, 1);
        e_iss(1, "R7"); e_iss(3, "R7"); e_iss(1, "R7"); e_iss(3, "R7"); e_idle("R9");
        run_scn();

        // R10: four bubbles saturate a two-bit count at 3
        begin_scn();
        wr_op(0, 5); ld_op(0, 5, 0); wr_op(0, 6); ld_op(0, 0, 6);
        e_iss(0, "R10"); e_bub("R10"); e_bub("R10"); e_iss(0, "R10");
        e_iss(0, "R10"); e_bub("R10"); e_bub("R10"); e_iss(0, "R10");
        run_scn();
        chk(stall_count == 2'd3, "R10", "saturated stall_count", int'(stall_count), 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule